// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector with Monitor Output Select

This block decides, for each of two phase-locked loops (an intermediate-frequency loop and a radio-frequency loop), whether the loop is in lock. A fast sample clock counts the time between the reference edge and the feedback edge seen at the phase-detector inputs, starting from whichever edge arrives first. Each measurement is then judged against two windows, both set in sample-clock ticks. A loop is declared locked only after a run of consecutive measurements that fall inside the tight window. It then stays locked until one measurement falls outside the wider window. If the second edge never arrives, that cycle counts as out of window.

A per-loop power-down flag resets that loop's measurement and clears its lock at once. A 3-bit select picks what appears on a single monitor pin. The choices are the lock of either loop, the AND of both locks, the raw reference or feedback pulse of either loop, or a fixed level that stands in for an analog open-drain lock mode. The reference and feedback inputs may be asynchronous to the sample clock: a parameterised synchronizer depth sits in front of the edge detectors.

Top module: `lockdet_top`

## Requirements
- R1: After reset both lock outputs are low.
- R2: A loop's lock output rises only after LOCK_COUNT (default 5) consecutive measurements whose error is strictly less than TIGHT_TICKS. One measurement fewer leaves it low.
- R3: The error is counted from the first-arriving edge to the second. Feedback-leading and reference-leading cycles are judged alike, and coincident edges give an error of 0.
- R4: While unlocked, any measurement that is not below TIGHT_TICKS (including one equal to it) clears the run of good measurements to zero.
- R5: While locked, errors up to and including WIDE_TICKS keep the lock. A single error greater than WIDE_TICKS drops it.
- R6: A first edge with no opposite edge within MAX_WAIT_TICKS counts as an out-of-window measurement. So does a repeat of the same first edge before the opposite one.
- R7: While a loop's power-down flag is high its lock output is low in that same cycle, its edges are ignored, and its run of good measurements is cleared.
- R8: Monitor select 3'b100 shows IF lock, 3'b010 shows RF lock, and 3'b110 shows IF lock AND RF lock.
- R9: Monitor select 3'b001 shows the raw IF reference input, 3'b101 the raw IF feedback input, 3'b011 the raw RF reference input and 3'b111 the raw RF feedback input.
- R10: Monitor select 3'b000 (analog lock mode) drives the constant ANALOG_LEVEL (default 1).
- R11: The two loops are independent: stimulus on one loop does not change the other loop's lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock that times the phase error |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_ref | input | 1 | IF loop reference divider pulse |
| if_fb | input | 1 | IF loop feedback divider pulse |
| rf_ref | input | 1 | RF loop reference divider pulse |
| rf_fb | input | 1 | RF loop feedback divider pulse |
| if_pd | input | 1 | IF loop power-down flag |
| rf_pd | input | 1 | RF loop power-down flag |
| mon_sel | input | 3 | Monitor output select code |
| mon_out | output | 1 | Multifunction monitor output |
| if_lock | output | 1 | IF loop lock indication |
| rf_lock | output | 1 | RF loop lock indication |

## Verification
The lock filter is driven with runs of edge pairs at chosen offsets. Runs of four and five good pairs separate the run length. An offset equal to the tight window separates strict from non-strict comparison while unlocked. Offsets of exactly the wide window and one tick beyond it pin the hold threshold. Feedback-leading pairs and coincident pairs show that the error is measured from whichever edge arrives first. A lone reference edge shows that a missing edge counts as a failure. A power-down pulse in the middle of a run shows that partial progress is discarded. Each monitor code is then walked while the two loops sit in different lock states, and the raw codes are exercised with single-input pulses, so that a swapped or misdecoded code is visible.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

   typedef enum logic [1:0] {
      MS_IDLE     = 2'd0,
      MS_WAIT_FB  = 2'd1,
      MS_WAIT_REF = 2'd2
   } meas_state_e;

   localparam logic [2:0] SEL_ANALOG  = 3'b000;
   localparam logic [2:0] SEL_IF_LOCK = 3'b100;
   localparam logic [2:0] SEL_RF_LOCK = 3'b010;
   localparam logic [2:0] SEL_BOTH    = 3'b110;
   localparam logic [2:0] SEL_IF_RDIV = 3'b001;
   localparam logic [2:0] SEL_IF_NDIV = 3'b101;
   localparam logic [2:0] SEL_RF_RDIV = 3'b011;
   localparam logic [2:0] SEL_RF_NDIV = 3'b111;

   localparam int NUM_LOOPS = 2;
   localparam int LOOP_IF   = 0;
   localparam int LOOP_RF   = 1;

endpackage

// File: rtl/lockdet_sync.sv
module lockdet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sr[i] <= 1'b0;
                  else        sr[i] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sr[i] <= 1'b0;
                  else        sr[i] <= sr[i-1];
               end
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lockdet_phase_meas.sv
module lockdet_phase_meas
   import lockdet_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int MAX_WAIT_TICKS = 255,
   localparam int CW            = $clog2(MAX_WAIT_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_dn,
   input  logic          ref_in,
   input  logic          fb_in,
   output logic          res_valid,
   output logic [CW-1:0] res_err,
   output logic          res_miss
);
   logic ref_s, fb_s, ref_d, fb_d, ref_rise, fb_rise;
   meas_state_e   st;
   logic [CW-1:0] cnt;

   lockdet_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
      .clk(clk), .rst_n(rst_n), .d(ref_in), .q(ref_s));
   lockdet_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
      .clk(clk), .rst_n(rst_n), .d(fb_in), .q(fb_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_d <= 1'b0;
         fb_d  <= 1'b0;
      end else begin
         ref_d <= ref_s;
         fb_d  <= fb_s;
      end
   end

   assign ref_rise = ref_s & ~ref_d;
   assign fb_rise  = fb_s & ~fb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= MS_IDLE;
         cnt       <= '0;
         res_valid <= 1'b0;
         res_err   <= '0;
         res_miss  <= 1'b0;
      end else if (pwr_dn) begin
         st        <= MS_IDLE;
         cnt       <= '0;
         res_valid <= 1'b0;
         res_miss  <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         res_miss  <= 1'b0;
         unique case (st)
            MS_IDLE: begin
               if (ref_rise && fb_rise) begin
                  res_valid <= 1'b1;
                  res_err   <= '0;
               end else if (ref_rise) begin
                  st  <= MS_WAIT_FB;
                  cnt <= CW'(1);
               end else if (fb_rise) begin
                  st  <= MS_WAIT_REF;
                  cnt <= CW'(1);
               end
            end
            MS_WAIT_FB: begin
               if (fb_rise) begin
                  res_valid <= 1'b1;
                  res_err   <= cnt;
                  st        <= MS_IDLE;
               end else if (ref_rise) begin
                  res_valid <= 1'b1;
                  res_miss  <= 1'b1;
                  res_err   <= cnt;
                  cnt       <= CW'(1);
               end else if (cnt == CW'(MAX_WAIT_TICKS)) begin
                  res_valid <= 1'b1;
                  res_miss  <= 1'b1;
                  res_err   <= cnt;
                  st        <= MS_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            MS_WAIT_REF: begin
               if (ref_rise) begin
                  res_valid <= 1'b1;
                  res_err   <= cnt;
                  st        <= MS_IDLE;
               end else if (fb_rise) begin
                  res_valid <= 1'b1;
                  res_miss  <= 1'b1;
                  res_err   <= cnt;
                  cnt       <= CW'(1);
               end else if (cnt == CW'(MAX_WAIT_TICKS)) begin
                  res_valid <= 1'b1;
                  res_miss  <= 1'b1;
                  res_err   <= cnt;
                  st        <= MS_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: st <= MS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lockdet_hyst.sv
module lockdet_hyst #(
   parameter int CW          = 8,
   parameter int TIGHT_TICKS = 3,
   parameter int WIDE_TICKS  = 6,
   parameter int LOCK_COUNT  = 5,
   localparam int KW         = (LOCK_COUNT < 2) ? 1 : $clog2(LOCK_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_dn,
   input  logic          res_valid,
   input  logic [CW-1:0] res_err,
   input  logic          res_miss,
   output logic          lock_o
);
   logic          locked;
   logic [KW-1:0] run;
   logic          in_tight, beyond_wide;

   assign in_tight    = !res_miss && (res_err < CW'(TIGHT_TICKS));
   assign beyond_wide = res_miss || (res_err > CW'(WIDE_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         run    <= '0;
      end else if (pwr_dn) begin
         locked <= 1'b0;
         run    <= '0;
      end else if (res_valid) begin
         if (!locked) begin
            if (!in_tight) begin
               run <= '0;
            end else if (run == KW'(LOCK_COUNT - 1)) begin
               locked <= 1'b1;
               run    <= '0;
            end else begin
               run <= run + KW'(1);
            end
         end else if (beyond_wide) begin
            locked <= 1'b0;
            run    <= '0;
         end
      end
   end

   assign lock_o = locked & ~pwr_dn;
endmodule

// File: rtl/lockdet_outsel.sv
module lockdet_outsel
   import lockdet_pkg::*;
#(
   parameter logic ANALOG_LEVEL = 1'b1
) (
   input  logic [NUM_LOOPS-1:0] lock,
   input  logic [NUM_LOOPS-1:0] ref_raw,
   input  logic [NUM_LOOPS-1:0] fb_raw,
   input  logic [2:0]           sel,
   output logic                 mon
);
   always_comb begin
      unique case (sel)
         SEL_ANALOG:  mon = ANALOG_LEVEL;
         SEL_IF_LOCK: mon = lock[LOOP_IF];
         SEL_RF_LOCK: mon = lock[LOOP_RF];
         SEL_BOTH:    mon = lock[LOOP_IF] & lock[LOOP_RF];
         SEL_IF_RDIV: mon = ref_raw[LOOP_IF];
         SEL_IF_NDIV: mon = fb_raw[LOOP_IF];
         SEL_RF_RDIV: mon = ref_raw[LOOP_RF];
         SEL_RF_NDIV: mon = fb_raw[LOOP_RF];
         default:     mon = ANALOG_LEVEL;
      endcase
   end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
   import lockdet_pkg::*;
#(
   parameter int   SYNC_STAGES    = 2,
   parameter int   MAX_WAIT_TICKS = 255,
   parameter int   TIGHT_TICKS    = 3,
   parameter int   WIDE_TICKS     = 6,
   parameter int   LOCK_COUNT     = 5,
   parameter logic ANALOG_LEVEL   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       if_ref,
   input  logic       if_fb,
   input  logic       rf_ref,
   input  logic       rf_fb,
   input  logic       if_pd,
   input  logic       rf_pd,
   input  logic [2:0] mon_sel,
   output logic       mon_out,
   output logic       if_lock,
   output logic       rf_lock
);
   localparam int CW = $clog2(MAX_WAIT_TICKS + 1);

   if (TIGHT_TICKS < 1) begin : g_chk_tight
      $error("TIGHT_TICKS must be at least 1");
   end
   if (WIDE_TICKS < TIGHT_TICKS) begin : g_chk_wide
      $error("WIDE_TICKS must not be below TIGHT_TICKS");
   end
   if (MAX_WAIT_TICKS <= WIDE_TICKS) begin : g_chk_wait
      $error("MAX_WAIT_TICKS must exceed WIDE_TICKS");
   end
   if (LOCK_COUNT < 1) begin : g_chk_count
      $error("LOCK_COUNT must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_chk_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [NUM_LOOPS-1:0]         ref_v, fb_v, pd_v, lock_v;
   logic [NUM_LOOPS-1:0]         m_valid, m_miss;
   logic [NUM_LOOPS-1:0][CW-1:0] m_err;

   assign ref_v = {rf_ref, if_ref};
   assign fb_v  = {rf_fb, if_fb};
   assign pd_v  = {rf_pd, if_pd};

   for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
      lockdet_phase_meas #(
         .SYNC_STAGES(SYNC_STAGES), .MAX_WAIT_TICKS(MAX_WAIT_TICKS)
      ) u_meas (
         .clk(clk), .rst_n(rst_n), .pwr_dn(pd_v[g]),
         .ref_in(ref_v[g]), .fb_in(fb_v[g]),
         .res_valid(m_valid[g]), .res_err(m_err[g]), .res_miss(m_miss[g]));

      lockdet_hyst #(
         .CW(CW), .TIGHT_TICKS(TIGHT_TICKS), .WIDE_TICKS(WIDE_TICKS),
         .LOCK_COUNT(LOCK_COUNT)
      ) u_hyst (
         .clk(clk), .rst_n(rst_n), .pwr_dn(pd_v[g]),
         .res_valid(m_valid[g]), .res_err(m_err[g]), .res_miss(m_miss[g]),
         .lock_o(lock_v[g]));
   end

   lockdet_outsel #(.ANALOG_LEVEL(ANALOG_LEVEL)) u_outsel (
      .lock(lock_v), .ref_raw(ref_v), .fb_raw(fb_v),
      .sel(mon_sel), .mon(mon_out));

   assign if_lock = lock_v[LOOP_IF];
   assign rf_lock = lock_v[LOOP_RF];
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
   parameter int   CW           = 8,
   parameter int   TIGHT_TICKS  = 3,
   parameter int   WIDE_TICKS   = 6,
   parameter logic ANALOG_LEVEL = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           pd,
   input logic [1:0]           lock,
   input logic [1:0]           valid,
   input logic [1:0]           miss,
   input logic [1:0][CW-1:0]   err,
   input logic [2:0]           sel,
   input logic                 mon
);
   for (genvar g = 0; g < 2; g++) begin : g_loop
      // R7: power-down holds the lock low in the same cycle
      a_r7_pd_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
         pd[g] |-> !lock[g]);

      // R2: lock rises only right after an in-window measurement
      a_r2_rise_after_tight: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lock[g]) |-> ($past(valid[g]) && !$past(miss[g])
                             && ($past(err[g]) < CW'(TIGHT_TICKS))));

      // R5: lock falls only on power-down or an out-of-wide-window result
      a_r5_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(lock[g]) |-> (pd[g] || $past(pd[g]) ||
                             ($past(valid[g]) && ($past(miss[g]) ||
                              ($past(err[g]) > CW'(WIDE_TICKS))))));
   end

   // R8
   a_r8_if_lock_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'b100) |-> (mon == lock[0]));
   a_r8_both_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'b110) |-> (mon == (lock[0] && lock[1])));
   // R10
   a_r10_analog_const: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'b000) |-> (mon == ANALOG_LEVEL));
endmodule

bind lockdet_top lockdet_chk #(
   .CW(CW), .TIGHT_TICKS(TIGHT_TICKS), .WIDE_TICKS(WIDE_TICKS),
   .ANALOG_LEVEL(ANALOG_LEVEL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pd(pd_v), .lock(lock_v),
   .valid(m_valid), .miss(m_miss), .err(m_err),
   .sel(mon_sel), .mon(mon_out));

// File: tb/lockdet_top_bench.sv
module lockdet_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TIGHT      = 3;
   localparam int WIDE       = 6;
   localparam int NLOCK      = 5;
   localparam int MAXW       = 20;
   localparam int IDLE_GAP   = 30;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_ref = 0, if_fb = 0, rf_ref = 0, rf_fb = 0;
   logic if_pd = 0, rf_pd = 0;
   logic [2:0] mon_sel = 3'b000;
   logic mon_out, if_lock, rf_lock;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lockdet_top #(
      .SYNC_STAGES(2), .MAX_WAIT_TICKS(MAXW), .TIGHT_TICKS(TIGHT),
      .WIDE_TICKS(WIDE), .LOCK_COUNT(NLOCK), .ANALOG_LEVEL(1'b1)
   ) u_lockdet_top (
      .clk(clk), .rst_n(rst_n), .if_ref(if_ref), .if_fb(if_fb),
      .rf_ref(rf_ref), .rf_fb(rf_fb), .if_pd(if_pd), .rf_pd(rf_pd),
      .mon_sel(mon_sel), .mon_out(mon_out), .if_lock(if_lock), .rf_lock(rf_lock));

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_sig(input int lp, input bit is_fb, input logic v);
      if (lp == 0) begin
         if (is_fb) if_fb = v; else if_ref = v;
      end else begin
         if (is_fb) rf_fb = v; else rf_ref = v;
      end
   endtask

   // one comparison cycle: first edge, second edge d ticks later, then idle
   task automatic pair(input int lp, input int d, input bit fb_first, input bit drop);
      @(negedge clk);
      set_sig(lp, fb_first, 1'b1);
      if (d == 0 && !drop) set_sig(lp, !fb_first, 1'b1);
      @(negedge clk);
      set_sig(lp, fb_first, 1'b0);
      set_sig(lp, !fb_first, 1'b0);
      if (d > 0 && !drop) begin
         repeat (d - 1) @(negedge clk);
         set_sig(lp, !fb_first, 1'b1);
         @(negedge clk);
         set_sig(lp, !fb_first, 1'b0);
      end
      repeat (IDLE_GAP) @(negedge clk);
   endtask

   task automatic good_run(input int lp, input int n, input int d, input bit fb_first);
      for (int i = 0; i < n; i++) pair(lp, d, fb_first, 1'b0);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1 if_lock after reset", if_lock, 1'b0);
      check("R1 rf_lock after reset", rf_lock, 1'b0);
      mon_sel = 3'b000; #1;
      check("R10 analog code constant", mon_out, 1'b1);
   endtask

   task automatic t_count;
      good_run(0, NLOCK - 1, 1, 1'b0);
      check("R2 one short of run stays unlocked", if_lock, 1'b0);
      pair(0, 1, 1'b0, 1'b0);
      check("R2 full run locks", if_lock, 1'b1);
      check("R11 rf unaffected by if stimulus", rf_lock, 1'b0);
      pair(0, WIDE + 4, 1'b0, 1'b0);
      check("R5 far error drops lock", if_lock, 1'b0);
   endtask

   task automatic t_fb_first;
      good_run(0, NLOCK, 2, 1'b1);
      check("R3 feedback-leading run locks", if_lock, 1'b1);
      pair(0, WIDE + 3, 1'b1, 1'b0);
      check("R3 feedback-leading large error drops", if_lock, 1'b0);
   endtask

   task automatic t_run_reset;
      good_run(0, NLOCK - 1, 0, 1'b0);
      pair(0, TIGHT, 1'b0, 1'b0);
      good_run(0, NLOCK - 1, 0, 1'b0);
      check("R4 error equal to tight window restarts run", if_lock, 1'b0);
      pair(0, 0, 1'b0, 1'b0);
      check("R4 run completes after restart", if_lock, 1'b1);
   endtask

   task automatic t_hold;
      pair(0, WIDE, 1'b0, 1'b0);
      check("R5 error equal to wide window holds", if_lock, 1'b1);
      pair(0, WIDE - 1, 1'b1, 1'b0);
      check("R5 error inside wide window holds", if_lock, 1'b1);
      pair(0, WIDE + 1, 1'b0, 1'b0);
      check("R5 one tick past wide window drops", if_lock, 1'b0);
   endtask

   task automatic t_missing;
      good_run(0, NLOCK, 1, 1'b0);
      check("R6 locked before missing edge", if_lock, 1'b1);
      pair(0, 0, 1'b0, 1'b1);
      check("R6 missing feedback edge drops lock", if_lock, 1'b0);
   endtask

   task automatic t_pd;
      good_run(1, NLOCK, 1, 1'b0);
      check("R7 rf locked before power-down", rf_lock, 1'b1);
      @(negedge clk); rf_pd = 1'b1; #1;
      check("R7 power-down forces lock low at once", rf_lock, 1'b0);
      pair(1, 1, 1'b0, 1'b0);
      rf_pd = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 lock stays low after power-up", rf_lock, 1'b0);
      good_run(1, 3, 1, 1'b0);
      @(negedge clk); rf_pd = 1'b1;
      repeat (2) @(negedge clk); rf_pd = 1'b0;
      good_run(1, 3, 1, 1'b0);
      check("R7 power-down cleared partial run", rf_lock, 1'b0);
      good_run(1, 2, 1, 1'b0);
      check("R7 fresh run locks", rf_lock, 1'b1);
   endtask

   task automatic t_mux_lock;
      // IF unlocked, RF locked here
      mon_sel = 3'b100; #1; check("R8 if lock code", mon_out, 1'b0);
      mon_sel = 3'b010; #1; check("R8 rf lock code", mon_out, 1'b1);
      mon_sel = 3'b110; #1; check("R8 both code one locked", mon_out, 1'b0);
      mon_sel = 3'b000;
      good_run(0, NLOCK, 1, 1'b0);
      mon_sel = 3'b100; #1; check("R8 if lock code locked", mon_out, 1'b1);
      mon_sel = 3'b110; #1; check("R8 both code both locked", mon_out, 1'b1);
      mon_sel = 3'b000; #1; check("R10 analog code while locked", mon_out, 1'b1);
   endtask

   task automatic raw_probe(input logic [2:0] code, input int lp, input bit is_fb, input string req);
      @(negedge clk); mon_sel = code; #1;
      check(req, mon_out, 1'b0);
      @(negedge clk); set_sig(lp, is_fb, 1'b1); #1;
      check(req, mon_out, 1'b1);
      @(negedge clk); set_sig(lp, is_fb, 1'b0); #1;
      check(req, mon_out, 1'b0);
      repeat (IDLE_GAP) @(negedge clk);
   endtask

   task automatic t_mux_raw;
      raw_probe(3'b001, 0, 1'b0, "R9 if reference code");
      raw_probe(3'b101, 0, 1'b1, "R9 if feedback code");
      raw_probe(3'b011, 1, 1'b0, "R9 rf reference code");
      raw_probe(3'b111, 1, 1'b1, "R9 rf feedback code");
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_fb_first();
      t_run_reset();
      t_hold();
      t_missing();
      t_pd();
      t_mux_lock();
      t_mux_raw();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule